// File: doc/BRIEF.md
# Spike-Timing Pair Update Engine

This block turns a stream of spike events into signed weight-change requests for a table of synaptic connections. It keeps a short history of recent presynaptic spikes and another of recent postsynaptic spikes. Each remembered spike carries a credit value that starts at a fixed window length and falls by one on every time step until it reaches zero. A postsynaptic spike pairs with earlier presynaptic spikes that still hold credit and produces strengthening requests. A presynaptic spike pairs with earlier postsynaptic spikes and produces weakening requests. Each request's size is the credit scaled by a power of two.

Events arrive on one strobe port. A kind bit selects presynaptic (0) or postsynaptic (1). A separate `tick` strobe marks a time step. Requests leave on a valid/ready port that carries the presynaptic address, the postsynaptic address and a two's-complement delta. The engine walks the opposite history from newest to oldest. It then records the triggering event in its own history. One further event can wait while a walk is running.

The controller has four states. IDLE waits for an event. SCAN reads one history entry. EMIT presents a request. PUSH records the finished event. The transitions are:
- IDLE→SCAN on an event.
- SCAN→EMIT on a live entry.
- SCAN→PUSH on an expired entry or at the end of the history.
- EMIT→SCAN when the request is accepted.
- PUSH→SCAN when an event is waiting or arriving.
- PUSH→IDLE otherwise.

Top module: `stdp_pair_engine`

## Requirements
- R1: After reset both histories are empty, `upd_valid`, `busy` and `ev_drop` are low, and `busy` is high exactly while an event is being handled.
- R2: A postsynaptic event (`ev_kind`=1) walks the presynaptic history newest first. It issues one request per live entry with `upd_pre` set to the entry address, `upd_post` set to the event address, and `upd_delta` = +(credit << ETA_SHIFT).
- R3: A presynaptic event (`ev_kind`=0) walks the postsynaptic history newest first. It issues one request per live entry with `upd_pre` set to the event address, `upd_post` set to the entry address, and `upd_delta` = -(credit << ETA_SHIFT).
- R4: A recorded presynaptic spike starts with credit TAU_PLUS and a postsynaptic one with TAU_MINUS. Every `tick` lowers all stored credits by one, and a credit never goes below zero. An entry written in a tick cycle starts at its full window.
- R5: A walk ends at the first entry with zero credit or after the oldest entry, whichever comes first. No request is issued for older entries.
- R6: Each history holds DEPTH entries. Recording into a full history replaces its oldest entry.
- R7: An event is recorded in its own history only after its walk ends, so a walk only ever sees events accepted before it.
- R8: While `upd_valid` is high and `upd_ready` is low, the request fields stay unchanged.
- R9: During a walk, one arriving event is held and handled next. An arrival while that slot is full is lost and pulses `ev_drop` in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One time step elapsed |
| ev_valid | input | 1 | Spike event strobe |
| ev_kind | input | 1 | 0 presynaptic, 1 postsynaptic |
| ev_addr | input | ADDR_W | Neuron address of the spike |
| upd_ready | input | 1 | Table accepts the request |
| upd_valid | output | 1 | Request present |
| upd_pre | output | ADDR_W | Presynaptic address of the synapse |
| upd_post | output | ADDR_W | Postsynaptic address of the synapse |
| upd_delta | output | DELTA_W | Signed weight change |
| busy | output | 1 | Event in progress |
| ev_drop | output | 1 | An arriving event was lost this cycle |

## Verification
An event sampled at an edge in IDLE gives its first request in the cycle after the next edge, because SCAN sits between them. After an accepted request, the next one comes two edges later. The walk's own record is written at the edge that leaves PUSH. `ev_drop` is combinational and shows in the same cycle as the lost arrival. The bench applies inputs just after the falling edge and compares every output one time unit later against a behavioural model. It then advances the model by exactly one edge. Every cycle-offset above is therefore checked at its exact cycle rather than inside a window.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2,
        ST_PUSH = 2'd3
    } walk_state_e;
endpackage

// File: rtl/stdp_spike_queue.sv
module stdp_spike_queue #(
    parameter int DEPTH    = 8,
    parameter int ADDR_W   = 5,
    parameter int TAU_W    = 5,
    parameter int TAU_INIT = 12,
    localparam int PW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [CW-1:0]     rd_back,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [TAU_W-1:0]  rd_credit,
    output logic [CW-1:0]     fill
);
    logic [ADDR_W-1:0] addr_mem   [DEPTH];
    logic [TAU_W-1:0]  credit_mem [DEPTH];
    logic [PW-1:0]     head;
    logic [PW-1:0]     slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            fill <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_mem[i]   <= '0;
                credit_mem[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && PW'(i) == head) begin
                    addr_mem[i]   <= push_addr;
                    credit_mem[i] <= TAU_W'(TAU_INIT);
                end else if (tick && credit_mem[i] != '0) begin
                    credit_mem[i] <= credit_mem[i] - 1'b1;
                end
            end
            if (push) begin
                head <= head + 1'b1;
                if (fill != CW'(DEPTH))
                    fill <= fill + 1'b1;
            end
        end
    end

    // newest entry sits one slot behind the write pointer
    assign slot      = head - 1'b1 - PW'(rd_back);
    assign rd_addr   = addr_mem[slot];
    assign rd_credit = credit_mem[slot];
endmodule

// File: rtl/stdp_event_hold.sv
module stdp_event_hold #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              can_accept,
    input  logic              take_hold,
    output logic              hold_valid,
    output logic              hold_kind,
    output logic [ADDR_W-1:0] hold_addr,
    output logic              ev_drop
);
    logic park;

    assign park    = ev_valid && !can_accept && !hold_valid;
    assign ev_drop = ev_valid && !can_accept && hold_valid && !take_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_kind  <= 1'b0;
            hold_addr  <= '0;
        end else if (take_hold) begin
            hold_valid <= ev_valid;
            hold_kind  <= ev_kind;
            hold_addr  <= ev_addr;
        end else if (park) begin
            hold_valid <= 1'b1;
            hold_kind  <= ev_kind;
            hold_addr  <= ev_addr;
        end
    end
endmodule

// File: rtl/stdp_walk_fsm.sv
module stdp_walk_fsm
    import stdp_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int ADDR_W    = 5,
    parameter int TAU_W     = 5,
    parameter int ETA_SHIFT = 2,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int DELTA_W  = TAU_W + ETA_SHIFT + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_valid,
    input  logic                      ev_kind,
    input  logic [ADDR_W-1:0]         ev_addr,
    input  logic                      hold_valid,
    input  logic                      hold_kind,
    input  logic [ADDR_W-1:0]         hold_addr,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [TAU_W-1:0]          rd_credit,
    input  logic [CW-1:0]             rd_fill,
    input  logic                      upd_ready,
    output logic [CW-1:0]             back,
    output logic                      cur_kind,
    output logic [ADDR_W-1:0]         cur_addr,
    output logic                      push_pre,
    output logic                      push_post,
    output logic                      can_accept,
    output logic                      take_hold,
    output logic                      busy,
    output logic                      upd_valid,
    output logic [ADDR_W-1:0]         upd_pre,
    output logic [ADDR_W-1:0]         upd_post,
    output logic signed [DELTA_W-1:0] upd_delta
);
    walk_state_e state, state_nx;
    logic              walk_end;
    logic              load_cur;
    logic [ADDR_W-1:0] lat_addr;
    logic [TAU_W-1:0]  lat_credit;
    logic [DELTA_W-1:0] mag;

    assign walk_end = (back == rd_fill) || (rd_credit == '0);
    assign load_cur = (state == ST_IDLE && ev_valid)
                   || (state == ST_PUSH && (hold_valid || ev_valid));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ev_valid) state_nx = ST_SCAN;
            ST_SCAN: state_nx = walk_end ? ST_PUSH : ST_EMIT;
            ST_EMIT: if (upd_ready) state_nx = ST_SCAN;
            ST_PUSH: state_nx = (hold_valid || ev_valid) ? ST_SCAN : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind   <= 1'b0;
            cur_addr   <= '0;
            back       <= '0;
            lat_addr   <= '0;
            lat_credit <= '0;
        end else begin
            if (load_cur) begin
                back <= '0;
                if (state == ST_PUSH && hold_valid) begin
                    cur_kind <= hold_kind;
                    cur_addr <= hold_addr;
                end else begin
                    cur_kind <= ev_kind;
                    cur_addr <= ev_addr;
                end
            end else if (state == ST_EMIT && upd_ready) begin
                back <= back + 1'b1;
            end
            if (state == ST_SCAN && !walk_end) begin
                lat_addr   <= rd_addr;
                lat_credit <= rd_credit;
            end
        end
    end

    assign mag = DELTA_W'(lat_credit) << ETA_SHIFT;

    always_comb begin
        upd_valid  = (state == ST_EMIT);
        busy       = (state != ST_IDLE);
        push_pre   = (state == ST_PUSH) && !cur_kind;
        push_post  = (state == ST_PUSH) && cur_kind;
        take_hold  = (state == ST_PUSH) && hold_valid;
        can_accept = (state == ST_IDLE) || (state == ST_PUSH && !hold_valid);
        upd_pre    = cur_kind ? lat_addr : cur_addr;
        upd_post   = cur_kind ? cur_addr : lat_addr;
        upd_delta  = cur_kind ? $signed(mag) : -$signed(mag);
    end
endmodule

// File: rtl/stdp_pair_engine.sv
module stdp_pair_engine #(
    parameter int DEPTH     = 8,
    parameter int ADDR_W    = 5,
    parameter int TAU_W     = 5,
    parameter int TAU_PLUS  = 12,
    parameter int TAU_MINUS = 20,
    parameter int ETA_SHIFT = 2,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int DELTA_W  = TAU_W + ETA_SHIFT + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      ev_valid,
    input  logic                      ev_kind,
    input  logic [ADDR_W-1:0]         ev_addr,
    input  logic                      upd_ready,
    output logic                      upd_valid,
    output logic [ADDR_W-1:0]         upd_pre,
    output logic [ADDR_W-1:0]         upd_post,
    output logic signed [DELTA_W-1:0] upd_delta,
    output logic                      busy,
    output logic                      ev_drop
);
    if (TAU_MINUS <= TAU_PLUS || TAU_MINUS >= (1 << TAU_W)) begin : g_bad_window
        $error("depression window must exceed potentiation window and fit TAU_W");
    end

    logic [ADDR_W-1:0] q_addr   [2];
    logic [TAU_W-1:0]  q_credit [2];
    logic [CW-1:0]     q_fill   [2];
    logic              q_push   [2];

    logic [CW-1:0]     back;
    logic              cur_kind;
    logic [ADDR_W-1:0] cur_addr;
    logic              push_pre, push_post;
    logic              can_accept, take_hold;
    logic              hold_valid, hold_kind;
    logic [ADDR_W-1:0] hold_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [TAU_W-1:0]  rd_credit;
    logic [CW-1:0]     rd_fill;

    assign q_push[0] = push_pre;
    assign q_push[1] = push_post;

    // index 0 keeps presynaptic spikes, index 1 postsynaptic spikes
    for (genvar g = 0; g < 2; g++) begin : g_hist
        localparam int TAU_G = (g == 0) ? TAU_PLUS : TAU_MINUS;
        stdp_spike_queue #(
            .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAU_W(TAU_W), .TAU_INIT(TAU_G)
        ) u_hist (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .push(q_push[g]), .push_addr(cur_addr),
            .rd_back(back),
            .rd_addr(q_addr[g]), .rd_credit(q_credit[g]), .fill(q_fill[g])
        );
    end

    // a postsynaptic walk reads the presynaptic history and vice versa
    assign rd_addr   = cur_kind ? q_addr[0]   : q_addr[1];
    assign rd_credit = cur_kind ? q_credit[0] : q_credit[1];
    assign rd_fill   = cur_kind ? q_fill[0]   : q_fill[1];

    stdp_event_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
        .can_accept(can_accept), .take_hold(take_hold),
        .hold_valid(hold_valid), .hold_kind(hold_kind), .hold_addr(hold_addr),
        .ev_drop(ev_drop)
    );

    stdp_walk_fsm #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAU_W(TAU_W), .ETA_SHIFT(ETA_SHIFT)
    ) u_walk (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
        .hold_valid(hold_valid), .hold_kind(hold_kind), .hold_addr(hold_addr),
        .rd_addr(rd_addr), .rd_credit(rd_credit), .rd_fill(rd_fill),
        .upd_ready(upd_ready),
        .back(back), .cur_kind(cur_kind), .cur_addr(cur_addr),
        .push_pre(push_pre), .push_post(push_post),
        .can_accept(can_accept), .take_hold(take_hold), .busy(busy),
        .upd_valid(upd_valid), .upd_pre(upd_pre), .upd_post(upd_post),
        .upd_delta(upd_delta)
    );
endmodule

// File: rtl/stdp_pair_engine_chk.sv
module stdp_pair_engine_chk #(
    parameter int ADDR_W    = 5,
    parameter int DELTA_W   = 8,
    parameter int TAU_MINUS = 20,
    parameter int ETA_SHIFT = 2,
    localparam int MAXM     = TAU_MINUS << ETA_SHIFT,
    localparam int LOWMASK  = (1 << ETA_SHIFT) - 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ev_valid,
    input logic                      upd_ready,
    input logic                      upd_valid,
    input logic [ADDR_W-1:0]         upd_pre,
    input logic [ADDR_W-1:0]         upd_post,
    input logic signed [DELTA_W-1:0] upd_delta,
    input logic                      busy,
    input logic                      ev_drop
);
    a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !upd_ready |=> upd_valid && $stable(upd_pre)
                                    && $stable(upd_post) && $stable(upd_delta));

    a_r5_no_expired_request: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> upd_delta != '0);

    a_r4_delta_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_delta) <= MAXM) && (int'(upd_delta) >= -MAXM));

    a_r2_eta_scaled: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_delta) & LOWMASK) == 0);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !upd_valid && !ev_drop);

    a_r9_drop_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        ev_drop |-> ev_valid && busy);
endmodule

bind stdp_pair_engine stdp_pair_engine_chk #(
    .ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .TAU_MINUS(TAU_MINUS), .ETA_SHIFT(ETA_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .upd_ready(upd_ready),
    .upd_valid(upd_valid), .upd_pre(upd_pre), .upd_post(upd_post),
    .upd_delta(upd_delta), .busy(busy), .ev_drop(ev_drop)
);

// File: tb/sim_stdp_pair_engine.sv
module sim_stdp_pair_engine;
    localparam int DEPTH = 8, ADDR_W = 5, TAU_W = 5;
    localparam int TAU_PLUS = 12, TAU_MINUS = 20, ETA_SHIFT = 2;
    localparam int DELTA_W = TAU_W + ETA_SHIFT + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, ev_valid = 1'b0, ev_kind = 1'b0, upd_ready = 1'b1;
    logic [ADDR_W-1:0] ev_addr = '0;
    logic upd_valid, busy, ev_drop;
    logic [ADDR_W-1:0] upd_pre, upd_post;
    logic signed [DELTA_W-1:0] upd_delta;

    always #5 clk = ~clk;

    stdp_pair_engine #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAU_W(TAU_W),
        .TAU_PLUS(TAU_PLUS), .TAU_MINUS(TAU_MINUS), .ETA_SHIFT(ETA_SHIFT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_addr(ev_addr), .upd_ready(upd_ready),
        .upd_valid(upd_valid), .upd_pre(upd_pre), .upd_post(upd_post),
        .upd_delta(upd_delta), .busy(busy), .ev_drop(ev_drop)
    );

    typedef struct { int addr; int credit; } spike_t;
    spike_t pre_h[$];
    spike_t post_h[$];
    int ph = 0;             // 0 waiting, 1 reading, 2 offering, 3 recording
    int m_kind = 0, m_addr = 0, m_k = 0, m_lat_addr = 0, m_lat_cr = 0;
    int h_v = 0, h_kind = 0, h_addr = 0;
    int vectors = 0, miscompares = 0;
    string req = "R1";

    task automatic cmp(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int v, input int k, input int a, input int tk, input int rdy);
        int acc_direct, take_h, nph, do_push, p_kind, p_addr, n, e_drop;
        spike_t e;
        @(negedge clk);
        ev_valid = v[0]; ev_kind = k[0]; ev_addr = a[ADDR_W-1:0];
        tick = tk[0]; upd_ready = rdy[0];
        #1;
        acc_direct = (v != 0 && (ph == 0 || (ph == 3 && h_v == 0))) ? 1 : 0;
        take_h     = (ph == 3 && h_v != 0) ? 1 : 0;
        e_drop     = (v != 0 && acc_direct == 0 && h_v != 0 && take_h == 0) ? 1 : 0;
        cmp("upd_valid", int'(upd_valid), (ph == 2) ? 1 : 0);
        cmp("busy", int'(busy), (ph != 0) ? 1 : 0);
        cmp("ev_drop", int'(ev_drop), e_drop);
        if (ph == 2) begin
            cmp("upd_pre",  int'(upd_pre),  m_kind != 0 ? m_lat_addr : m_addr);
            cmp("upd_post", int'(upd_post), m_kind != 0 ? m_addr : m_lat_addr);
            cmp("upd_delta", int'(upd_delta),
                (m_kind != 0 ? 1 : -1) * (m_lat_cr * (1 << ETA_SHIFT)));
        end
        // advance the model by one edge
        nph = ph; do_push = 0; p_kind = m_kind; p_addr = m_addr;
        case (ph)
            0: if (v != 0) begin m_kind = k; m_addr = a; m_k = 0; nph = 1; end
            1: begin
                n = (m_kind != 0) ? pre_h.size() : post_h.size();
                if (m_k >= n) nph = 3;
                else begin
                    e = (m_kind != 0) ? pre_h[m_k] : post_h[m_k];
                    if (e.credit == 0) nph = 3;
                    else begin m_lat_addr = e.addr; m_lat_cr = e.credit; nph = 2; end
                end
            end
            2: if (rdy != 0) begin m_k++; nph = 1; end
            default: begin
                do_push = 1;
                if (take_h != 0) begin m_kind = h_kind; m_addr = h_addr; m_k = 0; nph = 1; end
                else if (v != 0) begin m_kind = k; m_addr = a; m_k = 0; nph = 1; end
                else nph = 0;
            end
        endcase
        if (take_h != 0) begin h_v = v; h_kind = k; h_addr = a; end
        else if (v != 0 && acc_direct == 0 && h_v == 0) begin h_v = 1; h_kind = k; h_addr = a; end
        if (tk != 0) begin
            foreach (pre_h[i])  if (pre_h[i].credit > 0)  pre_h[i].credit--;
            foreach (post_h[i]) if (post_h[i].credit > 0) post_h[i].credit--;
        end
        if (do_push != 0) begin
            e.addr = p_addr;
            e.credit = (p_kind != 0) ? TAU_MINUS : TAU_PLUS;
            if (p_kind != 0) begin post_h.push_front(e); if (post_h.size() > DEPTH) void'(post_h.pop_back()); end
            else begin pre_h.push_front(e); if (pre_h.size() > DEPTH) void'(pre_h.pop_back()); end
        end
        ph = nph;
    endtask

    task automatic spike(input int k, input int a); step(1, k, a, 0, 1); endtask
    task automatic idle(input int n); for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1); endtask
    task automatic ticks(input int n); for (int i = 0; i < n; i++) step(0, 0, 0, 1, 1); endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        req = "R1"; idle(4);
        // R4 credits start at the window and fall per tick
        req = "R4";
        spike(0, 1); idle(6); ticks(3);
        spike(0, 2); idle(6); ticks(2);
        spike(0, 3); idle(6);
        req = "R2"; spike(1, 9); idle(14);
        req = "R3"; spike(1, 4); idle(6); ticks(5);
        spike(0, 7); idle(14);
        // R8 stall the request port
        req = "R8"; spike(1, 10); idle(1);
        for (int i = 0; i < 6; i++) step(0, 0, 0, i % 3 == 0 ? 1 : 0, 0);
        idle(20);
        // R5 expired entries end the walk
        req = "R5"; ticks(13); spike(1, 11); idle(6);
        spike(0, 5); idle(10); ticks(3); spike(1, 12); idle(10);
        // R6 overwrite of the oldest entry
        req = "R6"; ticks(25);
        for (int i = 0; i < 10; i++) begin spike(0, 16 + i); idle(4); end
        spike(1, 13); idle(24);
        // R9 one held, further arrivals lost
        req = "R9"; spike(1, 14); spike(0, 26); spike(0, 27); spike(1, 15); idle(50);
        // R7 an event never meets itself
        req = "R7"; ticks(25); spike(0, 3); idle(4); spike(1, 2); idle(8);
        req = "R2";
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4 == 0) ? 1 : 0, int'($urandom % 2), int'($urandom % 32),
                 ($urandom % 3 == 0) ? 1 : 0, ($urandom % 4 != 0) ? 1 : 0);
        idle(60);
        finish_run();
    end
endmodule